// File: doc/BRIEF.md
# Flash Bulk-Erase Command Sequencer

This block is the device-side command logic of a byte-wide flash array that can only be erased as a whole. It watches the write strobe, chip select, output enable and data bus of a host write. Erasing takes two writes of the erase opcode: the first arms the sequencer, and the second starts an erase pulse that covers the whole array. A stop timer removes the pulse by itself once its maximum length has passed. A separate verify opcode ends any running pulse and moves the device into a verify-read mode. The byte address given with that write is latched, so the host can read the location back and compare it.

After every verify command a short recovery interval must pass before the read data is valid. Both the pulse limit and the recovery interval are counted in clock cycles derived from a clock-frequency parameter. A programming-voltage-good input gates the whole sequence: losing it aborts any operation at once. The analog erase physics, the storage array and the host's retry loop lie outside this block.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `mode` is 0 (read), and `erase_on`, `busy` and `vfy_ready` are all low.
- R2: A qualified write of 20h in read mode moves `mode` to 1 (armed) on the next clock. `erase_on` stays low while armed.
- R3: A qualified write of 20h while armed moves `mode` to 2 (erasing) and raises `erase_on` and `busy` on the next clock.
- R4: A qualified write of any value other than 20h while armed, A0h included, returns `mode` to 0 without raising `erase_on`.
- R5: If no A0h arrives, `erase_on` stays high for exactly ERASE_CYC = CLK_KHZ*ERASE_US/1000 cycles. Then `mode` becomes 3 (timed out), and `erase_on` and `busy` go low.
- R6: A qualified write of A0h in mode 0, 2 or 3 drops `erase_on` on the next clock, sets `mode` to 4 (verify), and latches `addr` into `vfy_addr`.
- R7: After each accepted A0h, `vfy_ready` stays low and `busy` stays high for RECOV_CYC = ceil(CLK_KHZ*RECOV_NS/1e6) cycles. Then `vfy_ready` goes high and `busy` goes low.
- R8: A write counts only when `we_n` rises while `ce_n` is low and `oe_n` is high. Any other bus activity leaves the state unchanged.
- R9: The address given with 20h writes is ignored: `vfy_addr` keeps its value across an erase setup and confirm.
- R10: While `vpp_ok` is low, `mode` is forced to 0 on the next clock, `erase_on`, `busy` and `vfy_ready` are low, and all writes are ignored.
- R11: In verify mode, a new A0h re-latches the address and restarts recovery, 20h moves to mode 1, and any other value returns to mode 0.
- R12: In modes 2 and 3, qualified writes other than A0h are ignored, and a running pulse continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vpp_ok | input | 1 | High while the programming voltage is present |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, commands taken on its rising edge |
| dq | input | 8 | Command byte |
| addr | input | ADDR_W | Byte address |
| erase_on | output | 1 | Erase pulse control to the array |
| busy | output | 1 | Erase pulse or recovery interval running |
| mode | output | 3 | 0 read, 1 armed, 2 erasing, 3 timed out, 4 verify |
| vfy_ready | output | 1 | Verify read data valid |
| vfy_addr | output | ADDR_W | Address latched by the last verify command |

## Verification
The assertions assume that the bus inputs are synchronous to `clk`, so one rising edge of `we_n` is seen as one command. They also assume that `vpp_ok` changes only between clock edges. The stimulus drives every bus signal on the falling clock edge. It holds `we_n` low for a full cycle and keeps `ce_n` low across the rising edge of a qualified write. It lowers `vpp_ok` only on a falling edge. With these inputs, the pulse-length cap, the rule that a pulse is always preceded by arming, and the voltage-loss abort can be checked from the ports alone.

// File: rtl/fbe_pkg.sv
package fbe_pkg;

  typedef enum logic [2:0] {
    ST_READ   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_ERASE  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_VERIFY = 3'd4
  } seq_state_t;

  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_VERIFY = 8'hA0;

  // Pulse cap in cycles; never below one cycle.
  function automatic int unsigned erase_cycles(input int unsigned khz, input int unsigned us);
    int unsigned c;
    c = (khz * us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // Recovery interval in cycles, rounded up.
  function automatic int unsigned recov_cycles(input int unsigned khz, input int unsigned ns);
    return (khz * ns + 999_999) / 1_000_000;
  endfunction

endpackage

// File: rtl/fbe_rst_sync.sv
module fbe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fbe_cmd_decode.sv
module fbe_cmd_decode
  import fbe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic [7:0] dq,
  output logic       cmd_stb,
  output logic       cmd_erase,
  output logic       cmd_verify
);
  logic we_q;
  logic we_d;
  logic we_rise;

  always_comb we_d = we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_d;
  end

  assign we_rise    = we_n & ~we_q;
  assign cmd_stb    = we_rise & ~ce_n & oe_n;
  assign cmd_erase  = cmd_stb & (dq == OP_ERASE);
  assign cmd_verify = cmd_stb & (dq == OP_VERIFY);
endmodule

// File: rtl/fbe_interval_timer.sv
module fbe_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (load)               cnt_d = load_val;
    else if (en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fbe_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int CLK_KHZ    = 50_000,
  parameter int ERASE_US   = 10_000,
  parameter int RECOV_NS   = 6_000,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [7:0]        dq,
  input  logic [ADDR_W-1:0] addr,
  output logic              erase_on,
  output logic              busy,
  output logic [2:0]        mode,
  output logic              vfy_ready,
  output logic [ADDR_W-1:0] vfy_addr
);
  localparam int ERASE_CYC = int'(erase_cycles(CLK_KHZ, ERASE_US));
  localparam int RECOV_CYC = int'(recov_cycles(CLK_KHZ, RECOV_NS));
  localparam int EW = $clog2(ERASE_CYC + 1);
  localparam int RW = (RECOV_CYC < 1) ? 1 : $clog2(RECOV_CYC + 1);

  logic rst_n_s;
  logic cmd_stb, cmd_erase, cmd_verify;
  seq_state_t state_q, state_d;
  logic e_load, e_clr, e_zero;
  logic r_load, r_clr, r_zero;
  logic addr_ld;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;

  fbe_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fbe_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq(dq), .cmd_stb(cmd_stb), .cmd_erase(cmd_erase), .cmd_verify(cmd_verify)
  );

  fbe_interval_timer #(.W(EW)) u_stop_tmr (
    .clk(clk), .rst_n(rst_n_s), .clr(e_clr), .load(e_load),
    .load_val(EW'(ERASE_CYC - 1)), .en(state_q == ST_ERASE), .zero(e_zero)
  );

  fbe_interval_timer #(.W(RW)) u_recov_tmr (
    .clk(clk), .rst_n(rst_n_s), .clr(r_clr), .load(r_load),
    .load_val(RW'(RECOV_CYC)), .en(1'b1), .zero(r_zero)
  );

  // Next-state logic: voltage loss overrides every command.
  always_comb begin
    state_d = state_q;
    e_load  = 1'b0;
    e_clr   = 1'b0;
    r_load  = 1'b0;
    r_clr   = 1'b0;
    addr_ld = 1'b0;
    if (!vpp_ok) begin
      state_d = ST_READ;
      e_clr   = 1'b1;
      r_clr   = 1'b1;
    end else begin
      unique case (state_q)
        ST_READ: begin
          if (cmd_erase) state_d = ST_ARMED;
          else if (cmd_verify) begin
            state_d = ST_VERIFY;
            r_load  = 1'b1;
            addr_ld = 1'b1;
          end
        end
        ST_ARMED: begin
          if (cmd_erase) begin
            state_d = ST_ERASE;
            e_load  = 1'b1;
          end else if (cmd_stb) begin
            state_d = ST_READ;
          end
        end
        ST_ERASE: begin
          if (cmd_verify) begin
            state_d = ST_VERIFY;
            e_clr   = 1'b1;
            r_load  = 1'b1;
            addr_ld = 1'b1;
          end else if (e_zero) begin
            state_d = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cmd_verify) begin
            state_d = ST_VERIFY;
            r_load  = 1'b1;
            addr_ld = 1'b1;
          end
        end
        ST_VERIFY: begin
          if (cmd_verify) begin
            r_load  = 1'b1;
            addr_ld = 1'b1;
          end else if (cmd_erase) begin
            state_d = ST_ARMED;
            r_clr   = 1'b1;
          end else if (cmd_stb) begin
            state_d = ST_READ;
            r_clr   = 1'b1;
          end
        end
        default: state_d = ST_READ;
      endcase
    end
  end

  always_comb begin
    vaddr_d = vaddr_q;
    if (addr_ld) vaddr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_READ;
      vaddr_q <= '0;
    end else begin
      state_q <= state_d;
      vaddr_q <= vaddr_d;
    end
  end

  assign erase_on  = (state_q == ST_ERASE);
  assign busy      = erase_on | ~r_zero;
  assign vfy_ready = (state_q == ST_VERIFY) & r_zero;
  assign mode      = state_q;
  assign vfy_addr  = vaddr_q;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk
  import fbe_pkg::*;
#(
  parameter int CLK_KHZ  = 50_000,
  parameter int ERASE_US = 10_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vpp_ok,
  input logic       erase_on,
  input logic       busy,
  input logic [2:0] mode,
  input logic       vfy_ready
);
  localparam int ERASE_CYC = int'(erase_cycles(CLK_KHZ, ERASE_US));

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= 0;
    else if (erase_on) run_cnt <= run_cnt + 1;
    else               run_cnt <= 0;
  end

  p_armed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == ST_ARMED |-> !erase_on);

  p_arm_before_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_on) |-> $past(mode) == ST_ARMED);

  p_pulse_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_on |-> busy);

  p_pulse_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_on |-> run_cnt < ERASE_CYC);

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_ready |-> (mode == ST_VERIFY && !busy));

  p_vpp_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> (mode == ST_READ && !erase_on));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .CLK_KHZ(CLK_KHZ), .ERASE_US(ERASE_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .erase_on(erase_on),
  .busy(busy), .mode(mode), .vfy_ready(vfy_ready)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  // Bench settings: 1 MHz clock, 200 us cap, 6 us recovery.
  localparam int E_CYC = 200;   // 1000*200/1000
  localparam int R_CYC = 6;     // ceil(1000*6000/1e6)

  logic clk = 1'b0;
  logic rst_n, vpp_ok, ce_n, oe_n, we_n;
  logic [7:0] dq;
  logic [AW-1:0] addr;
  logic erase_on, busy, vfy_ready;
  logic [2:0] mode;
  logic [AW-1:0] vfy_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(AW), .CLK_KHZ(1000), .ERASE_US(200), .RECOV_NS(6000), .RST_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .dq(dq), .addr(addr), .erase_on(erase_on), .busy(busy),
    .mode(mode), .vfy_ready(vfy_ready), .vfy_addr(vfy_addr)
  );

  typedef struct {
    int            cyc;
    logic [2:0]    m;
    logic          er, bs, rd;
    logic          chk_addr;
    logic [AW-1:0] a;
    string         req;
  } exp_t;

  exp_t sb_q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Monitor: pops expected items whose cycle has come and compares.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        exp_t e;
        bit bad;
        e = sb_q.pop_front();
        n_checks++;
        bad = (mode !== e.m) || (erase_on !== e.er) || (busy !== e.bs) ||
              (vfy_ready !== e.rd) || (e.chk_addr && vfy_addr !== e.a);
        if (bad) begin
          n_fails++;
          $display("FAIL %s: got mode=%0d erase=%b busy=%b ready=%b addr=%h, expected mode=%0d erase=%b busy=%b ready=%b addr=%h",
                   e.req, mode, erase_on, busy, vfy_ready, vfy_addr,
                   e.m, e.er, e.bs, e.rd, e.a);
        end
      end
    end
  end

  task automatic expect_st(int dly, logic [2:0] m, logic er, logic bs, logic rd, string req);
    exp_t e;
    e.cyc = cyc + dly; e.m = m; e.er = er; e.bs = bs; e.rd = rd;
    e.chk_addr = 1'b0; e.a = '0; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic expect_ad(int dly, logic [2:0] m, logic er, logic bs, logic rd,
                           logic [AW-1:0] a, string req);
    exp_t e;
    e.cyc = cyc + dly; e.m = m; e.er = er; e.bs = bs; e.rd = rd;
    e.chk_addr = 1'b1; e.a = a; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Bus write; the rising strobe is seen at the next clock edge.
  task automatic bus_wr(logic c, logic o, logic [7:0] d, logic [AW-1:0] a);
    @(negedge clk);
    ce_n = c; oe_n = o; dq = d; addr = a; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] d, logic [AW-1:0] a);
    bus_wr(1'b0, 1'b1, d, a);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got no end, expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; vpp_ok = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    dq = '0; addr = '0;
    idle(2);
    expect_st(1, 3'd0, 0, 0, 0, "R1 reset state");
    idle(3);
    rst_n = 1'b1;
    idle(4);

    wr(8'h20, 15'h0005);
    expect_st(1, 3'd1, 0, 0, 0, "R2 first setup arms");
    idle(3);
    wr(8'h55, 15'h0000);
    expect_st(1, 3'd0, 0, 0, 0, "R4 bad confirm returns to read");
    idle(3);
    wr(8'h20, 15'h0000);
    idle(1);
    wr(8'hA0, 15'h0011);
    expect_st(1, 3'd0, 0, 0, 0, "R4 verify while armed returns to read");
    idle(3);

    bus_wr(1'b1, 1'b1, 8'h20, 15'h0);
    expect_st(1, 3'd0, 0, 0, 0, "R8 chip not selected");
    idle(3);
    bus_wr(1'b0, 1'b0, 8'h20, 15'h0);
    expect_st(1, 3'd0, 0, 0, 0, "R8 output enable low");
    idle(3);
    wr(8'h20, 15'h0);
    idle(1);
    bus_wr(1'b1, 1'b1, 8'h33, 15'h0);
    expect_st(1, 3'd1, 0, 0, 0, "R8 deselected write keeps armed");
    idle(3);

    wr(8'h20, 15'h0);
    expect_st(1, 3'd2, 1, 1, 0, "R3 confirm starts pulse");
    expect_st(E_CYC, 3'd2, 1, 1, 0, "R5 pulse still on at last cycle");
    expect_st(E_CYC + 1, 3'd3, 0, 0, 0, "R5 stop timer ends pulse");
    idle(E_CYC + 3);
    wr(8'h20, 15'h0);
    expect_st(1, 3'd3, 0, 0, 0, "R12 setup ignored after timeout");
    idle(3);

    wr(8'hA0, 15'h1234);
    expect_ad(1, 3'd4, 0, 1, 0, 15'h1234, "R6 verify from timed out");
    expect_st(R_CYC, 3'd4, 0, 1, 0, "R7 still recovering");
    expect_st(R_CYC + 1, 3'd4, 0, 0, 1, "R7 recovery done");
    idle(R_CYC + 3);

    wr(8'hA0, 15'h0042);
    expect_ad(1, 3'd4, 0, 1, 0, 15'h0042, "R11 next verify re-latches");
    expect_st(R_CYC + 1, 3'd4, 0, 0, 1, "R11 recovery restarted");
    idle(R_CYC + 3);
    wr(8'h00, 15'h0);
    expect_st(1, 3'd0, 0, 0, 0, "R11 other value back to read");
    idle(3);

    wr(8'h20, 15'h7FFF);
    idle(1);
    wr(8'h20, 15'h0001);
    expect_ad(1, 3'd2, 1, 1, 0, 15'h0042, "R9 setup address ignored");
    idle(10);
    wr(8'h5A, 15'h0);
    expect_st(1, 3'd2, 1, 1, 0, "R12 stray write during pulse");
    idle(3);
    wr(8'hA0, 15'h0100);
    expect_ad(1, 3'd4, 0, 1, 0, 15'h0100, "R6 verify cuts pulse");
    idle(R_CYC + 3);

    wr(8'h20, 15'h0);
    expect_st(1, 3'd1, 0, 0, 0, "R11 setup from verify arms");
    idle(2);
    wr(8'h20, 15'h0);
    idle(5);
    vpp_ok = 1'b0;
    expect_st(1, 3'd0, 0, 0, 0, "R10 voltage loss aborts");
    idle(3);
    wr(8'h20, 15'h0);
    expect_st(1, 3'd0, 0, 0, 0, "R10 writes ignored without voltage");
    idle(3);
    vpp_ok = 1'b1;
    idle(2);

    wr(8'hA0, 15'h0777);
    expect_ad(1, 3'd4, 0, 1, 0, 15'h0777, "R6 verify from read");
    idle(R_CYC + 5);

    if (sb_q.size() != 0) begin
      n_fails++;
      $display("FAIL scoreboard: got %0d pending, expected 0", sb_q.size());
    end
    finish_up();
  end
endmodule